// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block sits between a bank of 32 message mailboxes and a CAN protocol engine. It decides which mailbox the engine sends next. Each mailbox has an enable bit, a direction bit, an interrupt mask bit, a pending-request flag and a 14-bit control word. The control word carries a 6-bit transmit priority, a remote-frame marker and a 4-bit length code. Host software raises requests through a write-one-to-set register. It asks to withdraw requests through an abort register. It clears the completion and abort-completion flags through write-one-to-clear registers.

Arbitration runs only while no frame is in flight. The block compares every eligible mailbox. It then issues a one-cycle start strobe carrying the winner's index, length code and remote marker. The winner stays fixed until the engine reports a result. The engine returns a done pulse with a success bit. The block then retires the request and sets the matching acknowledge or abort-acknowledge flag. A global mailbox interrupt flag is raised when the mailbox is unmasked.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset, every request, acknowledge, abort-acknowledge, enable, direction, mask and control field is zero, and the outputs tx_start, busy and mb_irq are 0.
- R2: A mailbox takes part in arbitration only when its enable bit is 1, its direction bit is 0 (transmit) and its request flag is 1. Direction 1 marks a receive mailbox.
- R3: The control word has the length code in bits [3:0], the remote marker in bit 4 and the priority in bits [13:8]. The eligible mailbox with the numerically largest priority wins. tx_len and tx_rtr show the winner's fields.
- R4: When eligible mailboxes share the top priority value, the one with the higher mailbox number wins.
- R5: A write to the request-set register sets the request flag of each mailbox whose data bit is 1. Zero bits leave their flags unchanged.
- R6: When idle with an eligible mailbox, the block raises tx_start for exactly one cycle and enters the busy state. While busy, tx_idx holds and no new decision is made. A request raised meanwhile waits for the next decision.
- R7: A successful done pulse clears the in-flight mailbox's request flag and sets its acknowledge bit on the same clock edge. Acknowledge bits clear on a write of 1. A set and a clear of the same bit in one cycle leave the bit at 1.
- R8: An abort write for a mailbox that is waiting (requested, not in flight) clears its request and sets its abort-acknowledge bit on the next edge. An abort write for a mailbox with no request changes nothing. Abort-acknowledge bits clear on a write of 1.
- R9: An abort write for the in-flight mailbox raises tx_abort toward the engine. The engine's result then decides the outcome: done with success 0 sets abort-acknowledge and clears the request; done with success 1 sets acknowledge instead.
- R10: Each done pulse sets mb_irq when the completing mailbox's mask bit is 1. mb_irq_clr clears it. Setting and clearing in the same cycle leaves it at 1.
- R11: A done pulse while the block is idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_data | input | 32 | New enable bits, one per mailbox |
| dir_wr | input | 1 | Write strobe for the direction register |
| dir_data | input | 32 | New direction bits (1 = receive) |
| mask_wr | input | 1 | Write strobe for the interrupt mask register |
| mask_data | input | 32 | New interrupt mask bits |
| ctl_wr | input | 1 | Write strobe for one mailbox control word |
| ctl_idx | input | 5 | Mailbox addressed by ctl_wr |
| ctl_word | input | 14 | Control word: [13:8] priority, [4] remote, [3:0] length |
| req_set_wr | input | 1 | Write strobe for the request-set register |
| req_set_data | input | 32 | Write-one-to-set request bits |
| abort_wr | input | 1 | Write strobe for the abort register |
| abort_data | input | 32 | Mailboxes whose request is to be withdrawn |
| ack_clr_wr | input | 1 | Write strobe for acknowledge clearing |
| ack_clr_data | input | 32 | Write-one-to-clear acknowledge bits |
| aack_clr_wr | input | 1 | Write strobe for abort-acknowledge clearing |
| aack_clr_data | input | 32 | Write-one-to-clear abort-acknowledge bits |
| mb_irq_clr | input | 1 | Clears the global mailbox interrupt flag |
| eng_done | input | 1 | Engine result pulse for the in-flight frame |
| eng_ok | input | 1 | With eng_done: 1 = sent, 0 = aborted |
| tx_start | output | 1 | One-cycle start strobe to the engine |
| tx_idx | output | 5 | Mailbox chosen for the current frame |
| tx_len | output | 4 | Length code of the chosen mailbox |
| tx_rtr | output | 1 | Remote marker of the chosen mailbox |
| tx_abort | output | 1 | Host asked to abort the in-flight frame |
| busy | output | 1 | A frame is in flight |
| req_pend | output | 32 | Request flags |
| ack_flags | output | 32 | Transmit acknowledge flags |
| abort_ack | output | 32 | Abort acknowledge flags |
| mb_irq | output | 1 | Global mailbox interrupt flag |

## Verification
The engine's done pulse and the host's write-one-to-clear on the acknowledge register can land in the same cycle. The same holds for the done pulse and an interrupt-flag clear. The bench drives eng_done together with an acknowledge clear that covers both the completing mailbox and an older acknowledged one, and raises mb_irq_clr in the same cycle. It then checks that the new acknowledge bit and mb_irq survive while the older bit is gone. A second overlap, an abort write aimed at the in-flight mailbox, is judged by tx_abort rising and by the engine's result alone deciding which flag sets.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  localparam int MB_N         = 32;
  localparam int PRIO_W       = 6;
  localparam int LEN_W        = 4;
  localparam int CTL_W        = 14;
  localparam int CTL_PRIO_LSB = 8;
  localparam int CTL_RTR_BIT  = 4;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              rtr;
    logic [LEN_W-1:0]  len;
  } mb_ctl_t;

  typedef enum logic {ARB_IDLE = 1'b0, ARB_BUSY = 1'b1} arb_state_t;

  // Split a raw control word into its fields.
  function automatic mb_ctl_t ctl_decode(input logic [CTL_W-1:0] w);
    mb_ctl_t c;
    c.prio = w[CTL_PRIO_LSB +: PRIO_W];
    c.rtr  = w[CTL_RTR_BIT];
    c.len  = w[LEN_W-1:0];
    return c;
  endfunction

  // True when candidate a beats candidate b: larger priority, then larger index.
  function automatic logic outranks(input logic [PRIO_W-1:0] pa, input int ia,
                                    input logic [PRIO_W-1:0] pb, input int ib);
    return (pa > pb) || ((pa == pb) && (ia > ib));
  endfunction
endpackage

// File: rtl/txmb_ctl_store.sv
module txmb_ctl_store
  import txmb_pkg::*;
#(
  parameter int NMB = MB_N,
  localparam int IW = $clog2(NMB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [IW-1:0]       wr_idx,
  input  logic [CTL_W-1:0]    wr_word,
  output mb_ctl_t [NMB-1:0]   ctl_o
);
  for (genvar g = 0; g < NMB; g++) begin : g_mb
    mb_ctl_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (wr && (wr_idx == IW'(g))) r <= ctl_decode(wr_word);
    end
    assign ctl_o[g] = r;
  end

  // R3: a written control word is held in the addressed mailbox afterwards
  a_r3_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctl_o[$past(wr_idx)] == ctl_decode($past(wr_word)));
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick
  import txmb_pkg::*;
#(
  parameter int NMB = MB_N,
  localparam int IW = $clog2(NMB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NMB-1:0]    elig,
  input  mb_ctl_t [NMB-1:0] ctl,
  output logic              win_v,
  output logic [IW-1:0]     win_idx
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    best_p  = '0;
    for (int i = 0; i < NMB; i++) begin
      if (elig[i] && (!win_v || outranks(ctl[i].prio, i, best_p, int'(win_idx)))) begin
        win_v   = 1'b1;
        win_idx = IW'(i);
        best_p  = ctl[i].prio;
      end
    end
  end

  // R2: the chosen mailbox is always one that may take part
  a_r2_win_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    win_v |-> elig[win_idx]);
  // R2: no winner only when nobody is eligible
  a_r2_none_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !win_v |-> (elig == '0));
endmodule

// File: rtl/txmb_flags.sv
module txmb_flags
  import txmb_pkg::*;
#(
  parameter int NMB = MB_N,
  localparam int IW = $clog2(NMB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_wr,
  input  logic [NMB-1:0] en_data,
  input  logic           dir_wr,
  input  logic [NMB-1:0] dir_data,
  input  logic           mask_wr,
  input  logic [NMB-1:0] mask_data,
  input  logic           req_set_wr,
  input  logic [NMB-1:0] req_set_data,
  input  logic           abort_wr,
  input  logic [NMB-1:0] abort_data,
  input  logic           ack_clr_wr,
  input  logic [NMB-1:0] ack_clr_data,
  input  logic           aack_clr_wr,
  input  logic [NMB-1:0] aack_clr_data,
  input  logic           irq_clr,
  input  logic           fly_v,
  input  logic [IW-1:0]  fly_idx,
  input  logic           done_ev,
  input  logic           done_ok,
  input  logic [IW-1:0]  done_idx,
  output logic [NMB-1:0] en_o,
  output logic [NMB-1:0] dir_o,
  output logic [NMB-1:0] req_o,
  output logic [NMB-1:0] ack_o,
  output logic [NMB-1:0] aack_o,
  output logic [NMB-1:0] abp_o,
  output logic           irq_o
);
  logic [NMB-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      dir_o  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (en_wr)   en_o   <= en_data;
      if (dir_wr)  dir_o  <= dir_data;
      if (mask_wr) mask_q <= mask_data;
      irq_o <= (irq_o & ~irq_clr) | (done_ev & mask_q[done_idx]);
    end
  end

  for (genvar g = 0; g < NMB; g++) begin : g_bit
    logic hit, fly, abort_now, abort_fly;
    logic req_r, ack_r, aack_r, abp_r;
    assign hit       = done_ev && (done_idx == IW'(g));
    assign fly       = fly_v && (fly_idx == IW'(g));
    assign abort_now = abort_wr && abort_data[g] && !fly;
    assign abort_fly = abort_wr && abort_data[g] && fly && !hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_r  <= 1'b0;
        ack_r  <= 1'b0;
        aack_r <= 1'b0;
        abp_r  <= 1'b0;
      end else begin
        req_r  <= (req_r & ~(hit | abort_now)) | (req_set_wr & req_set_data[g]);
        ack_r  <= (ack_r & ~(ack_clr_wr & ack_clr_data[g])) | (hit & done_ok);
        aack_r <= (aack_r & ~(aack_clr_wr & aack_clr_data[g]))
                  | (hit & ~done_ok) | (abort_now & req_r);
        abp_r  <= hit ? 1'b0 : (abp_r | abort_fly);
      end
    end

    assign req_o[g]  = req_r;
    assign ack_o[g]  = ack_r;
    assign aack_o[g] = aack_r;
    assign abp_o[g]  = abp_r;
  end

  // R5: every bit written as 1 to the set register is raised afterwards
  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    req_set_wr |=> ((req_o & $past(req_set_data)) == $past(req_set_data)));
  // R7: a successful result leaves the acknowledge bit set
  a_r7_done_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && done_ok |=> ack_o[$past(done_idx)]);
  // R7: the result retires the request unless the host re-raised it
  a_r7_done_req: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && !(req_set_wr && req_set_data[done_idx]) |=> !req_o[$past(done_idx)]);
  // R9: an aborted result lands in the abort-acknowledge register
  a_r9_abort_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && !done_ok |=> aack_o[$past(done_idx)]);
  // R10: an unmasked completion raises the global flag
  a_r10_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev && mask_q[done_idx] |=> irq_o);
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter
  import txmb_pkg::*;
#(
  parameter int NMB = MB_N,
  localparam int IW = $clog2(NMB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [NMB-1:0]   en_data,
  input  logic             dir_wr,
  input  logic [NMB-1:0]   dir_data,
  input  logic             mask_wr,
  input  logic [NMB-1:0]   mask_data,
  input  logic             ctl_wr,
  input  logic [IW-1:0]    ctl_idx,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             req_set_wr,
  input  logic [NMB-1:0]   req_set_data,
  input  logic             abort_wr,
  input  logic [NMB-1:0]   abort_data,
  input  logic             ack_clr_wr,
  input  logic [NMB-1:0]   ack_clr_data,
  input  logic             aack_clr_wr,
  input  logic [NMB-1:0]   aack_clr_data,
  input  logic             mb_irq_clr,
  input  logic             eng_done,
  input  logic             eng_ok,
  output logic             tx_start,
  output logic [IW-1:0]    tx_idx,
  output logic [LEN_W-1:0] tx_len,
  output logic             tx_rtr,
  output logic             tx_abort,
  output logic             busy,
  output logic [NMB-1:0]   req_pend,
  output logic [NMB-1:0]   ack_flags,
  output logic [NMB-1:0]   abort_ack,
  output logic             mb_irq
);
  arb_state_t        st;
  logic              start_q;
  logic [IW-1:0]     cur_idx;
  mb_ctl_t [NMB-1:0] ctl_all;
  logic [NMB-1:0]    en_q, dir_q, abp;
  logic [NMB-1:0]    elig;
  logic              win_v;
  logic [IW-1:0]     win_idx;
  logic              launch, done_ev, fly_v;
  logic [IW-1:0]     fly_idx;

  assign elig    = en_q & ~dir_q & req_pend;
  assign launch  = (st == ARB_IDLE) && win_v;
  assign done_ev = (st == ARB_BUSY) && eng_done;
  assign fly_v   = (st == ARB_BUSY) || launch;
  assign fly_idx = (st == ARB_BUSY) ? cur_idx : win_idx;

  txmb_ctl_store #(.NMB(NMB)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wr_idx(ctl_idx), .wr_word(ctl_word),
    .ctl_o(ctl_all)
  );

  txmb_pick #(.NMB(NMB)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .ctl(ctl_all),
    .win_v(win_v), .win_idx(win_idx)
  );

  txmb_flags #(.NMB(NMB)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .en_wr(en_wr), .en_data(en_data),
    .dir_wr(dir_wr), .dir_data(dir_data),
    .mask_wr(mask_wr), .mask_data(mask_data),
    .req_set_wr(req_set_wr), .req_set_data(req_set_data),
    .abort_wr(abort_wr), .abort_data(abort_data),
    .ack_clr_wr(ack_clr_wr), .ack_clr_data(ack_clr_data),
    .aack_clr_wr(aack_clr_wr), .aack_clr_data(aack_clr_data),
    .irq_clr(mb_irq_clr),
    .fly_v(fly_v), .fly_idx(fly_idx),
    .done_ev(done_ev), .done_ok(eng_ok), .done_idx(cur_idx),
    .en_o(en_q), .dir_o(dir_q), .req_o(req_pend), .ack_o(ack_flags),
    .aack_o(abort_ack), .abp_o(abp), .irq_o(mb_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ARB_IDLE;
      start_q <= 1'b0;
      cur_idx <= '0;
    end else begin
      start_q <= launch;
      if (launch) begin
        st      <= ARB_BUSY;
        cur_idx <= win_idx;
      end else if (done_ev) begin
        st <= ARB_IDLE;
      end
    end
  end

  assign tx_start = start_q;
  assign tx_idx   = cur_idx;
  assign tx_len   = ctl_all[cur_idx].len;
  assign tx_rtr   = ctl_all[cur_idx].rtr;
  assign tx_abort = (st == ARB_BUSY) && abp[cur_idx];
  assign busy     = (st == ARB_BUSY);

  // R6: the start strobe never lasts two cycles
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  // R6: start only appears together with the busy state
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> busy);
  // R6: no re-decision while a frame is in flight
  a_r6_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !eng_done |=> busy && $stable(tx_idx));
  // R11: a done pulse while idle neither starts nor finishes anything by itself
  a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && eng_done && !win_v |=> !busy && !tx_start);
endmodule

// File: tb/tb_txmb_arbiter.sv
`timescale 1ns/1ps
module tb_txmb_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_wr = 0, dir_wr = 0, mask_wr = 0, ctl_wr = 0;
  logic [31:0] en_data = 0, dir_data = 0, mask_data = 0;
  logic [4:0]  ctl_idx = 0;
  logic [13:0] ctl_word = 0;
  logic        req_set_wr = 0, abort_wr = 0, ack_clr_wr = 0, aack_clr_wr = 0;
  logic [31:0] req_set_data = 0, abort_data = 0, ack_clr_data = 0, aack_clr_data = 0;
  logic        mb_irq_clr = 0, eng_done = 0, eng_ok = 0;
  logic        tx_start, tx_rtr, tx_abort, busy, mb_irq;
  logic [4:0]  tx_idx;
  logic [3:0]  tx_len;
  logic [31:0] req_pend, ack_flags, abort_ack;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  txmb_arbiter dut (
    .clk(clk), .rst_n(rst_n),
    .en_wr(en_wr), .en_data(en_data), .dir_wr(dir_wr), .dir_data(dir_data),
    .mask_wr(mask_wr), .mask_data(mask_data),
    .ctl_wr(ctl_wr), .ctl_idx(ctl_idx), .ctl_word(ctl_word),
    .req_set_wr(req_set_wr), .req_set_data(req_set_data),
    .abort_wr(abort_wr), .abort_data(abort_data),
    .ack_clr_wr(ack_clr_wr), .ack_clr_data(ack_clr_data),
    .aack_clr_wr(aack_clr_wr), .aack_clr_data(aack_clr_data),
    .mb_irq_clr(mb_irq_clr), .eng_done(eng_done), .eng_ok(eng_ok),
    .tx_start(tx_start), .tx_idx(tx_idx), .tx_len(tx_len), .tx_rtr(tx_rtr),
    .tx_abort(tx_abort), .busy(busy), .req_pend(req_pend), .ack_flags(ack_flags),
    .abort_ack(abort_ack), .mb_irq(mb_irq)
  );

  typedef struct packed {
    logic [4:0] ia; logic [5:0] pa;
    logic [4:0] ib; logic [5:0] pb;
    logic [4:0] ic; logic [5:0] pc;
    logic       c_rx;
    logic [4:0] exp;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{5'd3,  6'd10, 5'd7,  6'd5,  5'd1,  6'd2,  1'b0, 5'd3},
    '{5'd3,  6'd5,  5'd7,  6'd5,  5'd20, 6'd5,  1'b0, 5'd20},
    '{5'd0,  6'd63, 5'd31, 6'd0,  5'd15, 6'd62, 1'b0, 5'd0},
    '{5'd9,  6'd40, 5'd8,  6'd40, 5'd30, 6'd50, 1'b1, 5'd9},
    '{5'd31, 6'd63, 5'd30, 6'd63, 5'd29, 6'd63, 1'b0, 5'd31},
    '{5'd2,  6'd1,  5'd4,  6'd0,  5'd6,  6'd1,  1'b1, 5'd2}
  };

  function automatic logic [13:0] mk(input logic [5:0] p, input logic r, input logic [3:0] l);
    return {p, 3'b000, r, l};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic w_en(input logic [31:0] d);
    en_wr = 1; en_data = d; cyc(); en_wr = 0;
  endtask
  task automatic w_dir(input logic [31:0] d);
    dir_wr = 1; dir_data = d; cyc(); dir_wr = 0;
  endtask
  task automatic w_mask(input logic [31:0] d);
    mask_wr = 1; mask_data = d; cyc(); mask_wr = 0;
  endtask
  task automatic w_ctl(input logic [4:0] i, input logic [13:0] w);
    ctl_wr = 1; ctl_idx = i; ctl_word = w; cyc(); ctl_wr = 0;
  endtask
  task automatic w_req(input logic [31:0] d);
    req_set_wr = 1; req_set_data = d; cyc(); req_set_wr = 0;
  endtask
  task automatic w_abort(input logic [31:0] d);
    abort_wr = 1; abort_data = d; cyc(); abort_wr = 0;
  endtask
  task automatic w_ackclr(input logic [31:0] d);
    ack_clr_wr = 1; ack_clr_data = d; cyc(); ack_clr_wr = 0;
  endtask
  task automatic w_aackclr(input logic [31:0] d);
    aack_clr_wr = 1; aack_clr_data = d; cyc(); aack_clr_wr = 0;
  endtask
  task automatic fin(input logic ok);
    eng_done = 1; eng_ok = ok; cyc(); eng_done = 0; eng_ok = 0;
  endtask
  task automatic wait_start(output bit got);
    got = 0;
    for (int k = 0; k < 8 && !got; k++) begin
      cyc();
      if (tx_start) got = 1;
    end
  endtask
  task automatic no_start(input string req, input int n);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      cyc();
      if (tx_start) seen = 1;
    end
    chk(req, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got;
    logic [31:0] expack;
    int nfin;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 req", req_pend, 0);
    chk("R1 ack", ack_flags, 0);
    chk("R1 aack", abort_ack, 0);
    chk("R1 start/busy/irq", {29'd0, tx_start, busy, mb_irq}, 0);

    // R5 / R2: request on a disabled mailbox
    w_ctl(5'd20, mk(6'd3, 1'b0, 4'd8));
    w_req(32'h0010_0000 | 32'h0);
    chk("R5 set one bit", req_pend, 32'h0010_0000);
    w_req(32'h0);
    chk("R5 zero write no effect", req_pend, 32'h0010_0000);
    no_start("R2 disabled mailbox", 4);
    w_dir(32'h0010_0000);
    w_en(32'h0010_0000);
    no_start("R2 receive mailbox", 4);
    w_dir(32'h0);
    wait_start(got);
    chk("R2 start once transmit", {31'd0, got}, 1);
    chk("R3 idx", {27'd0, tx_idx}, 20);
    chk("R3 len", {28'd0, tx_len}, 8);
    fin(1'b1);
    chk("R7 ack after done", ack_flags, 32'h0010_0000);
    chk("R7 req retired", req_pend, 0);
    w_ackclr(32'hFFFF_FFFF);
    chk("R7 ack cleared", ack_flags, 0);
    w_en(0);

    // R3 / R4 vector table
    foreach (VT[v]) begin
      w_ctl(VT[v].ia, mk(VT[v].pa, VT[v].ia[0], VT[v].ia[3:0]));
      w_ctl(VT[v].ib, mk(VT[v].pb, VT[v].ib[0], VT[v].ib[3:0]));
      w_ctl(VT[v].ic, mk(VT[v].pc, VT[v].ic[0], VT[v].ic[3:0]));
      w_dir(VT[v].c_rx ? (32'd1 << VT[v].ic) : 32'd0);
      w_en((32'd1 << VT[v].ia) | (32'd1 << VT[v].ib) | (32'd1 << VT[v].ic));
      w_req((32'd1 << VT[v].ia) | (32'd1 << VT[v].ib) | (32'd1 << VT[v].ic));
      wait_start(got);
      chk("R3 R4 start seen", {31'd0, got}, 1);
      chk("R3 R4 winner", {27'd0, tx_idx}, {27'd0, VT[v].exp});
      chk("R3 winner len", {28'd0, tx_len}, {28'd0, VT[v].exp[3:0]});
      chk("R3 winner rtr", {31'd0, tx_rtr}, {31'd0, VT[v].exp[0]});
      fin(1'b1);
      nfin = 1;
      for (int k = 0; k < 3; k++) begin
        wait_start(got);
        if (got) begin nfin++; fin(1'b1); end
      end
      expack = (32'd1 << VT[v].ia) | (32'd1 << VT[v].ib)
             | (VT[v].c_rx ? 32'd0 : (32'd1 << VT[v].ic));
      chk("R2 completions", nfin, VT[v].c_rx ? 2 : 3);
      chk("R7 ack set", ack_flags, expack);
      w_ackclr(32'hFFFF_FFFF);
      w_abort(32'hFFFF_FFFF);
      w_aackclr(32'hFFFF_FFFF);
      w_en(0);
      w_dir(0);
    end

    // R6: a higher request during a frame waits
    w_ctl(5'd5, mk(6'd1, 1'b0, 4'd2));
    w_ctl(5'd6, mk(6'd63, 1'b1, 4'd7));
    w_mask(32'h0000_0040);
    w_en(32'h0000_0060);
    w_req(32'h0000_0020);
    wait_start(got);
    chk("R6 first start", {27'd0, tx_idx}, 5);
    w_req(32'h0000_0040);
    no_start("R6 no start while busy", 3);
    chk("R6 idx held", {27'd0, tx_idx}, 5);
    chk("R6 busy", {31'd0, busy}, 1);
    fin(1'b1);
    chk("R10 masked-off completion no irq", {31'd0, mb_irq}, 0);
    wait_start(got);
    chk("R6 waiting mailbox next", {27'd0, tx_idx}, 6);
    chk("R3 rtr of winner", {31'd0, tx_rtr}, 1);
    // R7 / R10: completion and host clears in one cycle
    eng_done = 1; eng_ok = 1; ack_clr_wr = 1; ack_clr_data = 32'h0000_0060; mb_irq_clr = 1;
    cyc();
    eng_done = 0; eng_ok = 0; ack_clr_wr = 0; mb_irq_clr = 0;
    chk("R7 set wins over clear, old bit cleared", ack_flags, 32'h0000_0040);
    chk("R10 irq set wins over clear", {31'd0, mb_irq}, 1);
    mb_irq_clr = 1; cyc(); mb_irq_clr = 0;
    chk("R10 irq cleared", {31'd0, mb_irq}, 0);

    // R11: done while idle
    fin(1'b1);
    chk("R11 ack unchanged", ack_flags, 32'h0000_0040);
    chk("R11 still idle", {30'd0, busy, mb_irq}, 0);
    w_ackclr(32'hFFFF_FFFF);
    w_mask(0);

    // R8 / R9 aborts
    w_ctl(5'd12, mk(6'd9, 1'b0, 4'd1));
    w_ctl(5'd11, mk(6'd1, 1'b0, 4'd1));
    w_en(32'h0000_1800);
    w_req(32'h0000_1800);
    wait_start(got);
    chk("R8 setup winner", {27'd0, tx_idx}, 12);
    w_abort(32'h0000_0800);
    chk("R8 waiting request withdrawn", req_pend, 32'h0000_1000);
    chk("R8 abort ack set", abort_ack, 32'h0000_0800);
    w_abort(32'h0000_2000);
    chk("R8 abort of idle mailbox no effect", abort_ack, 32'h0000_0800);
    chk("R8 abort of idle mailbox req", req_pend, 32'h0000_1000);
    w_abort(32'h0000_1000);
    chk("R9 abort flagged to engine", {31'd0, tx_abort}, 1);
    chk("R9 request kept while in flight", req_pend, 32'h0000_1000);
    fin(1'b0);
    chk("R9 aborted result flags", abort_ack, 32'h0000_1800);
    chk("R9 no ack", ack_flags, 0);
    chk("R9 req retired", req_pend, 0);
    no_start("R8 aborted mailbox not sent", 4);
    w_aackclr(32'h0000_0800);
    chk("R8 abort ack clear", abort_ack, 32'h0000_1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule